// File: doc/BRIEF.md
# Post-Modify Address Generator with Circular Buffers

This block computes memory addresses for a DSP data bus. It keeps a bank of register sets. Each set holds four values: an index (the current pointer), a modify (a signed step), a base (the lowest address of a buffer) and a length (the size of the buffer). When a request arrives, the block drives the current value of the chosen index onto the address output in the same cycle. At the next clock edge it moves that index by the chosen modify value.

When the length of the index's set is zero, the step is plain addition. When the length is nonzero, the pointer stays inside the window [base, base+length−1] by adding or subtracting the length once. A single write port loads any of the four register kinds. Writing an index also loads the base of the same set, so one write is enough to start a fresh buffer. The address width is a parameter, so one design serves either a 32-bit or a 24-bit bus.

Top module: `dag_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every index, modify, base and length register becomes zero. After reset, a request on any index returns address 0.
- R2: When `req_en` is high, `addr_out` equals the value that the index selected by `req_isel` held before that cycle's clock edge, in the same cycle. When `req_en` is low, `addr_out` is 0.
- R3: For a request whose index set has length 0, the index becomes (index + modify) mod 2^AW at the clock edge. The modify comes from the set chosen by `req_msel` and is read as two's complement.
- R4: For a request whose index set has nonzero length L and base B, if S = index + modify (computed without wrap) is at least B+L, the index becomes S−L, truncated to AW bits.
- R5: Under the same conditions as R4, if S is below B, the index becomes S+L, truncated to AW bits. If B ≤ S < B+L, the index becomes S.
- R6: A write with `wr_kind` = 0 loads both the index and the base of set `wr_sel` with `wr_data`.
- R7: When a write to an index and a request that updates the same index fall in the same cycle, the written value is kept. The request still returns the old index as its address.
- R8: The index select and the modify select are independent: any index may step by any of the modify registers.
- R9: An index changes only through a request on it or a write of kind 0 to it. Writes of kind 1 (modify), 2 (base) or 3 (length) leave every index unchanged, and so does a cycle with neither a request nor a write.
- R10: The write kind encoding is 0 = index (also base), 1 = modify, 2 = base only, 3 = length. Each kind loads only its own register of set `wr_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 2 | Register kind to write (0 index+base, 1 modify, 2 base, 3 length) |
| wr_sel | input | SEL_W | Register set to write |
| wr_data | input | AW | Write value |
| req_en | input | 1 | Address request |
| req_isel | input | SEL_W | Index register set for the request |
| req_msel | input | SEL_W | Modify register set for the request |
| addr_out | output | AW | Pre-modify address |

## Verification
The wrap checks assume a step never exceeds one buffer length: the magnitude of the modify is at most L. They also assume that base+length does not pass 2^AW, so that a single correction lands inside the window. When the modify register is larger than that, the window property is not claimed. The random stimulus keeps bases below a few thousand and lengths at 64 or below. It draws modify values within ±length of typical buffers, and a few directed cases reach the linear mod-2^AW wrap, where length is zero and no window applies.

// File: rtl/dag_pkg.sv
package dag_pkg;

    localparam int DEF_SETS = 8;

    typedef enum logic [1:0] {
        KIND_INDEX  = 2'd0,
        KIND_MODIFY = 2'd1,
        KIND_BASE   = 2'd2,
        KIND_LENGTH = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/dag_step.sv
// Next-index calculation: linear or single-correction circular.
module dag_step #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur_idx,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] win_base,
    input  logic [AW-1:0] win_len,
    output logic [AW-1:0] nxt_idx
);
    localparam int EW = AW + 2;

    logic signed [EW-1:0] idx_e, step_e, base_e, len_e, sum_e, top_e, res_e;

    always_comb begin
        idx_e  = $signed({2'b00, cur_idx});
        step_e = $signed({{2{step[AW-1]}}, step});
        base_e = $signed({2'b00, win_base});
        len_e  = $signed({2'b00, win_len});
        sum_e  = idx_e + step_e;
        top_e  = base_e + len_e;
        if (win_len == '0) begin
            res_e = sum_e;
        end else if (sum_e >= top_e) begin
            res_e = sum_e - len_e;
        end else if (sum_e < base_e) begin
            res_e = sum_e + len_e;
        end else begin
            res_e = sum_e;
        end
        nxt_idx = res_e[AW-1:0];
    end
endmodule

// File: rtl/dag_bank.sv
// Register sets: index, modify, base, length.
module dag_bank
    import dag_pkg::*;
#(
    parameter int AW       = 32,
    parameter int NUM_SETS = DEF_SETS,
    parameter int SEL_W    = $clog2(NUM_SETS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  reg_kind_e       wr_kind,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [AW-1:0]   wr_data,
    input  logic            upd_en,
    input  logic [SEL_W-1:0] upd_sel,
    input  logic [AW-1:0]   upd_val,
    output logic [AW-1:0]   idx_o  [NUM_SETS],
    output logic [AW-1:0]   mod_o  [NUM_SETS],
    output logic [AW-1:0]   base_o [NUM_SETS],
    output logic [AW-1:0]   len_o  [NUM_SETS]
);
    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        logic hit_wr;
        logic hit_upd;
        assign hit_wr  = wr_en && (wr_sel == SEL_W'(g));
        assign hit_upd = upd_en && (upd_sel == SEL_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                idx_o[g]  <= '0;
                mod_o[g]  <= '0;
                base_o[g] <= '0;
                len_o[g]  <= '0;
            end else begin
                // a write to the index takes priority over the post-modify
                if (hit_wr && wr_kind == KIND_INDEX) begin
                    idx_o[g] <= wr_data;
                end else if (hit_upd) begin
                    idx_o[g] <= upd_val;
                end
                if (hit_wr && (wr_kind == KIND_INDEX || wr_kind == KIND_BASE)) begin
                    base_o[g] <= wr_data;
                end
                if (hit_wr && wr_kind == KIND_MODIFY) begin
                    mod_o[g] <= wr_data;
                end
                if (hit_wr && wr_kind == KIND_LENGTH) begin
                    len_o[g] <= wr_data;
                end
            end
        end
    end
endmodule

// File: rtl/dag_addr_gen.sv
module dag_addr_gen
    import dag_pkg::*;
#(
    parameter int AW       = 32,
    parameter int NUM_SETS = DEF_SETS,
    parameter int SEL_W    = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_kind,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [AW-1:0]    wr_data,
    input  logic             req_en,
    input  logic [SEL_W-1:0] req_isel,
    input  logic [SEL_W-1:0] req_msel,
    output logic [AW-1:0]    addr_out
);
    logic [AW-1:0] idx_q  [NUM_SETS];
    logic [AW-1:0] mod_q  [NUM_SETS];
    logic [AW-1:0] base_q [NUM_SETS];
    logic [AW-1:0] len_q  [NUM_SETS];
    logic [AW-1:0] next_idx;

    dag_step #(.AW(AW)) u_step (
        .cur_idx (idx_q[req_isel]),
        .step    (mod_q[req_msel]),
        .win_base(base_q[req_isel]),
        .win_len (len_q[req_isel]),
        .nxt_idx (next_idx)
    );

    dag_bank #(.AW(AW), .NUM_SETS(NUM_SETS), .SEL_W(SEL_W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_kind(reg_kind_e'(wr_kind)),
        .wr_sel (wr_sel),
        .wr_data(wr_data),
        .upd_en (req_en),
        .upd_sel(req_isel),
        .upd_val(next_idx),
        .idx_o  (idx_q),
        .mod_o  (mod_q),
        .base_o (base_q),
        .len_o  (len_q)
    );

    assign addr_out = req_en ? idx_q[req_isel] : '0;
endmodule

// File: rtl/dag_addr_gen_chk.sv
module dag_addr_gen_chk #(
    parameter int AW       = 32,
    parameter int NUM_SETS = 8,
    parameter int SEL_W    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_kind,
    input logic [SEL_W-1:0] wr_sel,
    input logic [AW-1:0]    wr_data,
    input logic             req_en,
    input logic [SEL_W-1:0] req_isel,
    input logic [SEL_W-1:0] req_msel,
    input logic [AW-1:0]    addr_out,
    input logic [AW-1:0]    idx_q  [NUM_SETS],
    input logic [AW-1:0]    mod_q  [NUM_SETS],
    input logic [AW-1:0]    base_q [NUM_SETS],
    input logic [AW-1:0]    len_q  [NUM_SETS]
);
    localparam int EW = AW + 2;

    logic wr_idx_same;
    logic [EW-1:0] s_full, top_full, b_full, l_full;
    logic [NUM_SETS*AW-1:0] idx_flat;

    assign wr_idx_same = wr_en && wr_kind == 2'd0 && wr_sel == req_isel;
    assign b_full   = {2'b00, base_q[req_isel]};
    assign l_full   = {2'b00, len_q[req_isel]};
    assign s_full   = {2'b00, idx_q[req_isel]} + {{2{mod_q[req_msel][AW-1]}}, mod_q[req_msel]};
    assign top_full = b_full + l_full;

    always_comb begin
        for (int k = 0; k < NUM_SETS; k++) idx_flat[k*AW +: AW] = idx_q[k];
    end

    // R1: reset clears every index
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> idx_flat == '0);

    // R3: linear step
    a_r3_linear_step: assert property (@(posedge clk) disable iff (rst)
        (req_en && !wr_idx_same && len_q[req_isel] == '0)
        |=> idx_q[$past(req_isel)] == $past(s_full[AW-1:0]));

    // R4: step past the window top wraps down by one length
    a_r4_upper_wrap: assert property (@(posedge clk) disable iff (rst)
        (req_en && !wr_idx_same && len_q[req_isel] != '0 && !s_full[EW-1] && s_full >= top_full)
        |=> idx_q[$past(req_isel)] == $past(s_full[AW-1:0] - len_q[req_isel]));

    // R5: step below the base wraps up by one length
    a_r5_lower_wrap: assert property (@(posedge clk) disable iff (rst)
        (req_en && !wr_idx_same && len_q[req_isel] != '0 && (s_full[EW-1] || s_full < b_full))
        |=> idx_q[$past(req_isel)] == $past(s_full[AW-1:0] + len_q[req_isel]));

    // R6: index write also sets base
    a_r6_index_sets_base: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == 2'd0)
        |=> idx_q[$past(wr_sel)] == $past(wr_data) && base_q[$past(wr_sel)] == $past(wr_data));

    // R7: write wins over post-modify on the same index
    a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
        (req_en && wr_idx_same) |=> idx_q[$past(req_isel)] == $past(wr_data));

    // R9: idle cycle holds every index
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!req_en && !wr_en) |=> $stable(idx_flat));

    // R2: no request, no address
    a_r2_quiet_output: assert property (@(posedge clk) disable iff (rst)
        !req_en |-> addr_out == '0);
endmodule

bind dag_addr_gen dag_addr_gen_chk #(.AW(AW), .NUM_SETS(NUM_SETS), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/tb_dag_addr_gen.sv
module tb_dag_addr_gen;
    localparam int AW = 32;
    localparam int NS = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [1:0]    wr_kind;
    logic [SW-1:0] wr_sel;
    logic [AW-1:0] wr_data;
    logic          req_en;
    logic [SW-1:0] req_isel;
    logic [SW-1:0] req_msel;
    logic [AW-1:0] addr_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [AW-1:0] m_idx [NS];
    logic [AW-1:0] m_mod [NS];
    logic [AW-1:0] m_base[NS];
    logic [AW-1:0] m_len [NS];

    always #2 clk = ~clk;

    dag_addr_gen #(.AW(AW), .NUM_SETS(NS)) dut (.*);

    function automatic logic [AW-1:0] exp_next(logic [AW-1:0] i, logic [AW-1:0] m,
                                               logic [AW-1:0] b, logic [AW-1:0] l);
        longint s, lo, hi, ll;
        s  = longint'(i) + longint'($signed(m));
        lo = longint'(b);
        ll = longint'(l);
        hi = lo + ll;
        if (l != 0) begin
            if (s >= hi) s = s - ll;
            else if (s < lo) s = s + ll;
        end
        return s[AW-1:0];
    endfunction

    task automatic check(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < NS; k++) begin
            m_idx[k] = '0; m_mod[k] = '0; m_base[k] = '0; m_len[k] = '0;
        end
    endtask

    // one cycle: drive, check address, then advance the model at the edge
    task automatic step(string tag, bit we, logic [1:0] kd, int ws, logic [AW-1:0] wd,
                        bit re, int is, int ms);
        logic [AW-1:0] nx;
        @(negedge clk);
        wr_en = we; wr_kind = kd; wr_sel = SW'(ws); wr_data = wd;
        req_en = re; req_isel = SW'(is); req_msel = SW'(ms);
        #1;
        check(tag, addr_out, re ? m_idx[is] : '0);
        nx = exp_next(m_idx[is], m_mod[ms], m_base[is], m_len[is]);
        @(posedge clk);
        if (re) m_idx[is] = nx;
        if (we) begin
            case (kd)
                2'd0: begin m_idx[ws] = wd; m_base[ws] = wd; end
                2'd1: m_mod[ws] = wd;
                2'd2: m_base[ws] = wd;
                default: m_len[ws] = wd;
            endcase
        end
    endtask

    task automatic wr(int s, logic [1:0] kd, logic [AW-1:0] d);
        step("R10 write", 1, kd, s, d, 0, 0, 0);
    endtask

    task automatic rd(string tag, int is, int ms);
        step(tag, 0, 2'd0, 0, '0, 1, is, ms);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1; wr_en = 0; wr_kind = 0; wr_sel = 0; wr_data = 0;
        req_en = 0; req_isel = 0; req_msel = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: all indexes read zero after reset
        for (int k = 0; k < NS; k++) step("R1 reset index", 0, 0, 0, '0, 1, k, 0);
        step("R2 idle output", 0, 0, 0, '0, 0, 0, 0);

        // R6/R10: index write sets base; circular buffer base 100, length 10
        wr(2, 2'd0, 32'd100);
        wr(2, 2'd3, 32'd10);
        wr(5, 2'd1, 32'd3);
        for (int k = 0; k < 6; k++) rd("R4 upper wrap", 2, 5);
        check("R6 base follows index", m_base[2], 32'd100);
        // R5: negative step below base
        wr(6, 2'd1, 32'hFFFF_FFFD);
        for (int k = 0; k < 6; k++) rd("R5 lower wrap", 2, 6);
        // R8: the same index with a different modify set
        rd("R8 cross modify", 2, 5);
        // R9: modify/base/length writes leave indexes alone
        wr(2, 2'd1, 32'd77);
        wr(2, 2'd2, 32'd300);
        step("R9 idle", 0, 0, 0, '0, 0, 0, 0);
        rd("R9 index held", 2, 0);
        // R3: linear wrap modulo 2^AW
        wr(1, 2'd0, 32'hFFFF_FFFE);
        wr(3, 2'd1, 32'd5);
        rd("R3 linear", 1, 3);
        rd("R3 linear wrapped", 1, 3);
        // R7: same-cycle write beats post-modify
        step("R7 collision addr", 1, 2'd0, 1, 32'h1234, 1, 1, 3);
        rd("R7 write kept", 1, 0);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 99));
            if (r < 30) begin
                int s = int'($urandom_range(0, NS - 1));
                logic [1:0] kd = 2'($urandom_range(0, 3));
                logic [AW-1:0] d;
                case (kd)
                    2'd0: d = AW'($urandom_range(0, 4000));
                    2'd1: d = AW'(int'($urandom_range(0, 128)) - 64);
                    2'd2: d = AW'($urandom_range(0, 4000));
                    default: d = ($urandom_range(0, 3) == 0) ? '0 : AW'($urandom_range(1, 64));
                endcase
                step("R10 random write", 1, kd, s, d, $urandom_range(0, 1), $urandom_range(0, NS - 1), $urandom_range(0, NS - 1));
            end else if (r < 90) begin
                rd("R2 random access", $urandom_range(0, NS - 1), $urandom_range(0, NS - 1));
            end else begin
                step("R9 random idle", 0, 0, 0, '0, 0, 0, 0);
            end
        end

        // R1: reset again clears everything
        @(negedge clk); rst = 1; wr_en = 0; req_en = 0;
        @(posedge clk); model_reset();
        @(negedge clk); rst = 0;
        for (int k = 0; k < NS; k++) rd("R1 reset again", k, k);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule